// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is the arithmetic core of a small integer datapath. It takes two operand words and a three-bit operation code. It returns a result word, a flag that is high when the result is all zeros, and a flag for signed overflow. It supports bitwise AND, bitwise OR, addition, subtraction and a signed less-than test. The block is purely combinational, so the result is valid in the same cycle as its inputs.

All arithmetic goes through one adder. The top bit of the operation code inverts operand B and sets the adder carry-in to one, which turns the adder into a subtractor. The less-than test uses that subtraction. The zero flag lets a control unit test two operands for equality: it subtracts one from the other and looks at the flag. The adder is built from carry-lookahead groups, and the carry ripples from one group to the next.

Top module: `int_alu`

## Requirements
- R1: Op code 3'b000 returns A AND B, bit by bit.
- R2: Op code 3'b001 returns A OR B, bit by bit.
- R3: Op code 3'b010 returns A + B modulo 2^W.
- R4: Op code 3'b110 returns A - B modulo 2^W. This equals A plus the inverted B plus a carry-in of one.
- R5: Op code 3'b111 returns 1 in bit 0 and zeros in all other bits when A < B as two's-complement values, and all zeros otherwise. The answer is correct even when A - B overflows.
- R6: `zero` is 1 exactly when every bit of `result` is 0.
- R7: For op 3'b010, `ovf` is 1 when both operands have the same sign bit and the sum's sign bit differs from it.
- R8: For op 3'b110, `ovf` is 1 when the operands' sign bits differ and the difference's sign bit differs from A's sign bit.
- R9: Adding operands of opposite sign, or subtracting operands of the same sign, never raises `ovf`.
- R10: Op codes 3'b011, 3'b100 and 3'b101 return a zero result. `ovf` is 0 for every op code other than 3'b010 and 3'b110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| op | input | 3 | Operation code |
| result | output | W | Selected result word |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest case to reach is a less-than test whose internal subtraction overflows. In that case the sign of the difference gives the wrong answer, and only the correction from the overflow term makes the result right. Random operands seldom land there. The directed stimulus therefore pairs the most negative value against large positive values, and the most positive value against negative values. It also drives the exact boundary pairs where A - B just reaches, or just misses, the signed limits. The same operand pairs go through add and subtract, so the overflow flag is checked on both sides of each limit.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Signed overflow from the carries into and out of the top bit.
  function automatic logic f_ovf_from_carry(input logic c_into_msb, input logic c_out_msb);
    return c_into_msb ^ c_out_msb;
  endfunction

  // Signed less-than from the sign of A-B, corrected by its overflow.
  function automatic logic f_signed_lt(input logic diff_sign, input logic diff_ovf);
    return diff_sign ^ diff_ovf;
  endfunction

  function automatic logic f_is_arith(input logic [OP_W-1:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W   = 32,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_msb,
  output logic         c_out
);
  localparam int NG = W / GRP;

  logic [W-1:0]  bx;
  logic [W-1:0]  carry;
  logic [NG:0]   gcarry;

  assign bx        = b ^ {W{sub}};
  assign gcarry[0] = sub;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    logic [GRP-1:0] gen;
    logic [GRP-1:0] prop;
    logic [GRP:0]   lc;

    assign gen  = a[gi*GRP +: GRP] & bx[gi*GRP +: GRP];
    assign prop = a[gi*GRP +: GRP] | bx[gi*GRP +: GRP];

    always_comb begin
      logic term;
      lc[0] = gcarry[gi];
      for (int k = 1; k <= GRP; k++) begin
        lc[k] = 1'b0;
        for (int j = 0; j < k; j++) begin
          term = gen[j];
          for (int m = j + 1; m < k; m++) term = term & prop[m];
          lc[k] = lc[k] | term;
        end
        term = gcarry[gi];
        for (int m = 0; m < k; m++) term = term & prop[m];
        lc[k] = lc[k] | term;
      end
    end

    assign carry[gi*GRP +: GRP] = lc[GRP-1:0];
    assign gcarry[gi+1]         = lc[GRP];
  end

  assign sum   = a ^ bx ^ carry;
  assign c_msb = carry[W-1];
  assign c_out = gcarry[NG];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_w,
  output logic [W-1:0] or_w
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_w[i] = a[i] & b[i];
    assign or_w[i]  = a[i] | b[i];
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] result,
  input  logic         c_msb,
  input  logic         c_out,
  input  logic         arith,
  output logic         raw_ovf,
  output logic         zero,
  output logic         ovf
);
  assign raw_ovf = alu_pkg::f_ovf_from_carry(c_msb, c_out);
  assign ovf     = arith & raw_ovf;
  assign zero    = ~|result;
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W   = 32,
  parameter int GRP = 4
) (
  input  logic [W-1:0]             a_in,
  input  logic [W-1:0]             b_in,
  input  logic [alu_pkg::OP_W-1:0] op,
  output logic [W-1:0]             result,
  output logic                     zero,
  output logic                     ovf
);
  import alu_pkg::*;

  logic [W-1:0] sum_w, and_w, or_w;
  logic         c_msb_w, c_out_w, raw_ovf_w, lt_w, arith_w;

  assign arith_w = f_is_arith(op);

  alu_adder #(.W(W), .GRP(GRP)) u_adder (
    .a(a_in), .b(b_in), .sub(op[OP_W-1]),
    .sum(sum_w), .c_msb(c_msb_w), .c_out(c_out_w)
  );

  alu_logic #(.W(W)) u_logic (
    .a(a_in), .b(b_in), .and_w(and_w), .or_w(or_w)
  );

  assign lt_w = f_signed_lt(sum_w[W-1], raw_ovf_w);

  always_comb begin
    unique case (op)
      OP_AND:  result = and_w;
      OP_OR:   result = or_w;
      OP_ADD,
      OP_SUB:  result = sum_w;
      OP_SLT:  result = {{(W-1){1'b0}}, lt_w};
      default: result = '0;
    endcase
  end

  alu_flags #(.W(W)) u_flags (
    .result(result), .c_msb(c_msb_w), .c_out(c_out_w), .arith(arith_w),
    .raw_ovf(raw_ovf_w), .zero(zero), .ovf(ovf)
  );
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [2:0]   op,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         ovf,
  input logic [W-1:0] sum_w
);
  always_comb begin
    if (op == 3'b000) assert_and_R1: assert (result == (a_in & b_in));
    if (op == 3'b001) assert_or_R2: assert (result == (a_in | b_in));
    if (op == 3'b111) assert_slt_shape_R5: assert (result[W-1:1] == '0);
    assert_zero_flag_R6: assert (!zero || (result == '0));
    if (op == 3'b010)
      assert_add_ovf_R7: assert (ovf == ((a_in[W-1] == b_in[W-1]) && (result[W-1] != a_in[W-1])));
    if (op == 3'b110)
      assert_sub_ovf_R8: assert (ovf == ((a_in[W-1] != b_in[W-1]) && (result[W-1] != a_in[W-1])));
    if (op == 3'b010 && a_in[W-1] != b_in[W-1]) assert_no_overflow_R9: assert (!ovf);
    if (op == 3'b110) assert_sub_sum_R4: assert (sum_w + b_in == a_in);
    if (op == 3'b011 || op == 3'b100 || op == 3'b101)
      assert_unused_R10: assert (result == '0 && !ovf);
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .a_in(a_in), .b_in(b_in), .op(op), .result(result),
  .zero(zero), .ovf(ovf), .sum_w(sum_w)
);

// File: tb/test_int_alu.sv
module test_int_alu;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a_in, b_in;
  logic [2:0]   op;
  logic [W-1:0] result;
  logic         zero, ovf;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 0;

  always #2 clk = ~clk;

  int_alu #(.W(W)) i_int_alu (
    .a_in(a_in), .b_in(b_in), .op(op),
    .result(result), .zero(zero), .ovf(ovf)
  );

  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c,
                       output logic [31:0] r, output logic z, output logic v);
    longint sa, sb, s;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = '0; v = 1'b0;
    case (c)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin s = sa + sb; r = s[31:0]; v = (s > SMAX) || (s < SMIN); end
      3'b110: begin s = sa - sb; r = s[31:0]; v = (s > SMAX) || (s < SMIN); end
      3'b111: r = (sa < sb) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    z = (r == 0);
  endtask

  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
    logic [31:0] er; logic ez, ev;
    @(negedge clk);
    a_in = a; b_in = b; op = c;
    @(posedge clk); #1;
    model(a, b, c, er, ez, ev);
    n_chk += 3;
    if (result !== er) begin n_bad++; $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", req, c, a, b, result, er); end
    if (zero !== ez) begin n_bad++; $display("FAIL %s/R6 zero op=%b a=%h b=%h actual=%b expected=%b", req, c, a, b, zero, ez); end
    if (ovf !== ev) begin n_bad++; $display("FAIL %s ovf op=%b a=%h b=%h actual=%b expected=%b", req, c, a, b, ovf, ev); end
  endtask

  task automatic t_idle;
    run("R1", 32'h0, 32'h0, 3'b000);
  endtask

  task automatic t_logic_R1_R2;
    run("R1", 32'hF0F0_1234, 32'hFF00_FF0F, 3'b000);
    run("R1", 32'hFFFF_FFFF, 32'hA5A5_5A5A, 3'b000);
    run("R2", 32'h0F0F_0000, 32'h0000_F0F1, 3'b001);
    run("R2", 32'h0, 32'h0, 3'b001);
  endtask

  task automatic t_add_R3_R7_R9;
    run("R3", 32'd7, 32'd35, 3'b010);
    run("R3", 32'hFFFF_FFFF, 32'd1, 3'b010);
    run("R7", 32'h7FFF_FFFF, 32'd1, 3'b010);
    run("R7", 32'h8000_0000, 32'h8000_0000, 3'b010);
    run("R7", 32'h8000_0000, 32'hFFFF_FFFF, 3'b010);
    run("R7", 32'h3FFF_FFFF, 32'h4000_0000, 3'b010);
    run("R9", 32'h7FFF_FFFF, 32'h8000_0000, 3'b010);
    run("R9", 32'h8000_0001, 32'h7FFF_FFFF, 3'b010);
  endtask

  task automatic t_sub_R4_R8_R9;
    run("R4", 32'd100, 32'd58, 3'b110);
    run("R4", 32'd5, 32'd5, 3'b110);
    run("R4", 32'd0, 32'd1, 3'b110);
    run("R8", 32'h8000_0000, 32'd1, 3'b110);
    run("R8", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    run("R8", 32'd0, 32'h8000_0000, 3'b110);
    run("R8", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 3'b110);
    run("R9", 32'h8000_0000, 32'hFFFF_FFFF, 3'b110);
    run("R9", 32'h7FFF_FFFF, 32'd0, 3'b110);
  endtask

  task automatic t_slt_R5;
    run("R5", 32'd3, 32'd9, 3'b111);
    run("R5", 32'd9, 32'd3, 3'b111);
    run("R5", 32'd4, 32'd4, 3'b111);
    run("R5", 32'hFFFF_FFFF, 32'd0, 3'b111);
    run("R5", 32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
    run("R5", 32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    run("R5", 32'h8000_0000, 32'd1, 3'b111);
    run("R5", 32'h4000_0000, 32'hBFFF_FFFF, 3'b111);
  endtask

  task automatic t_zero_R6;
    run("R6", 32'h1234_5678, 32'h1234_5678, 3'b110);
    run("R6", 32'h5555_5555, 32'hAAAA_AAAA, 3'b000);
    run("R6", 32'h8000_0000, 32'h8000_0000, 3'b010);
  endtask

  task automatic t_unused_R10;
    run("R10", 32'hFFFF_FFFF, 32'h1234_5678, 3'b011);
    run("R10", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b100);
    run("R10", 32'h8000_0000, 32'd1, 3'b101);
  endtask

  task automatic t_random;
    logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 4 == 0) ? a ^ (32'h1 << (i % 32)) : $urandom;
      run("R3/R4/R5 random", a, b, codes[i % 5]);
    end
  endtask

  initial begin
    a_in = '0; b_in = '0; op = '0;
    t_idle();
    t_logic_R1_R2();
    t_add_R3_R7_R9();
    t_sub_R4_R8_R9();
    t_slt_R5();
    t_zero_R6();
    t_unused_R10();
    t_random();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule